// File: doc/BRIEF.md
# ALU with Condition Flags

A 32-bit integer execution unit for a compact two-operand instruction set. Each operation combines two register operands (a source `a` and a destination `b`) under a 4-bit function code into an add, a subtract, a bitwise AND or a bitwise XOR. The result appears combinationally and is meant to be written back into `b`. The unit has no carry flag. Instead it keeps a three-bit signed condition register that holds overflow, zero and sign.

The condition register is loaded on the clock edge where the operate strobe is high and the function code is legal. A separate jump-evaluate strobe with a 4-bit jump function code asks whether a conditional branch is taken, judged against the flags as they currently stand. An illegal operate or jump code raises an invalid-code output for as long as its strobe is high, and it leaves the flags untouched.

Top module: `alu_cond_unit`

## Requirements
- R1: With function code 0 the result is b + a, and with code 1 it is b - a, both modulo 2^32.
- R2: With function code 2 the result is a AND b, and with code 3 it is a XOR b.
- R3: On an edge with the strobe high, an add sets overflow when both operands carry the same sign and the result's sign differs from it. A subtract sets overflow when a and b differ in sign and the result's sign differs from b.
- R4: On an edge with the strobe high and a legal code, zero is set exactly when the result is 0, and sign is set to result bit 31. AND and XOR clear overflow.
- R5: While the operate strobe is low, the flags keep their value across clock edges.
- R6: An active-low asynchronous reset clears all three flags.
- R7: An operate code above 3 with the strobe high drives the invalid-code output high, gives a result of 0 and leaves the flags unchanged.
- R8: With the jump strobe high, the taken output follows the jump code as follows. Code 0 is always taken. Code 1 (less or equal) is taken when (sign XOR overflow) OR zero. Code 2 (less) is taken when sign XOR overflow. Code 3 (equal) is taken when zero is set. Code 4 (not equal) is taken when zero is clear. Code 5 (greater or equal) is taken when sign equals overflow. Code 6 (greater) is taken when sign equals overflow and zero is clear.
- R9: The taken output is low whenever the jump strobe is low. A jump code above 6 with the strobe high keeps taken low and raises the invalid-code output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_a_i | input | 32 | Source operand a |
| src_b_i | input | 32 | Destination operand b |
| op_fn_i | input | 4 | Operation function code |
| op_valid_i | input | 1 | Operate strobe; loads the flags |
| jmp_fn_i | input | 4 | Jump condition code |
| jmp_eval_i | input | 1 | Jump evaluate strobe |
| result_o | output | 32 | Operation result |
| flag_of_o | output | 1 | Signed overflow flag |
| flag_zf_o | output | 1 | Zero flag |
| flag_sf_o | output | 1 | Sign flag |
| taken_o | output | 1 | Jump taken |
| bad_code_o | output | 1 | Invalid operate or jump code |

## Verification
The assertions assume that the operands and codes are stable around the clock edge that loads the flags. They also assume that a strobe with an illegal code is a legitimate input, not one that never occurs. The bench changes every input only at the falling edge, so each flag update sees settled values. Random function codes run one or two values past the legal range, which exercises the invalid paths. Directed cases hit the signed boundary values 0x7FFFFFFF and 0x80000000, as well as operands that cancel to zero.

// File: rtl/alu_cond_pkg.sv
package alu_cond_pkg;
  localparam int unsigned FN_W = 4;

  localparam logic [FN_W-1:0] OP_ADD = 4'd0;
  localparam logic [FN_W-1:0] OP_SUB = 4'd1;
  localparam logic [FN_W-1:0] OP_AND = 4'd2;
  localparam logic [FN_W-1:0] OP_XOR = 4'd3;
  localparam logic [FN_W-1:0] OP_MAX = OP_XOR;

  localparam logic [FN_W-1:0] JC_ALW = 4'd0;
  localparam logic [FN_W-1:0] JC_LE  = 4'd1;
  localparam logic [FN_W-1:0] JC_LT  = 4'd2;
  localparam logic [FN_W-1:0] JC_EQ  = 4'd3;
  localparam logic [FN_W-1:0] JC_NE  = 4'd4;
  localparam logic [FN_W-1:0] JC_GE  = 4'd5;
  localparam logic [FN_W-1:0] JC_GT  = 4'd6;
  localparam logic [FN_W-1:0] JC_MAX = JC_GT;

  typedef struct packed {
    logic of;
    logic zf;
    logic sf;
  } flags_t;
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_cond_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [FN_W-1:0] fn_i,
  output logic [W-1:0]    res_o,
  output flags_t          nxt_o,
  output logic            fn_ok_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] sum, dif;
  logic         ovf_add, ovf_sub;

  assign sum = b_i + a_i;
  assign dif = b_i - a_i;
  assign ovf_add = (a_i[MSB] == b_i[MSB]) && (sum[MSB] != b_i[MSB]);
  assign ovf_sub = (a_i[MSB] != b_i[MSB]) && (dif[MSB] != b_i[MSB]);
  assign fn_ok_o = (fn_i <= OP_MAX);

  always_comb begin
    res_o     = '0;
    nxt_o.of  = 1'b0;
    unique case (fn_i)
      OP_ADD: begin res_o = sum; nxt_o.of = ovf_add; end
      OP_SUB: begin res_o = dif; nxt_o.of = ovf_sub; end
      OP_AND: res_o = a_i & b_i;
      OP_XOR: res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
    nxt_o.zf = (res_o == '0);
    nxt_o.sf = res_o[MSB];
  end
endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import alu_cond_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  AST_NO_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> q_o == $past(q_o)); // R5
endmodule

// File: rtl/jump_decoder.sv
module jump_decoder
  import alu_cond_pkg::*;
(
  input  flags_t          fl_i,
  input  logic [FN_W-1:0] fn_i,
  input  logic            eval_i,
  output logic            taken_o,
  output logic            fn_ok_o
);
  logic lt, cond;

  assign lt      = fl_i.sf ^ fl_i.of;
  assign fn_ok_o = (fn_i <= JC_MAX);

  always_comb begin
    unique case (fn_i)
      JC_ALW:  cond = 1'b1;
      JC_LE:   cond = lt | fl_i.zf;
      JC_LT:   cond = lt;
      JC_EQ:   cond = fl_i.zf;
      JC_NE:   cond = ~fl_i.zf;
      JC_GE:   cond = ~lt;
      JC_GT:   cond = ~lt & ~fl_i.zf;
      default: cond = 1'b0;
    endcase
  end

  assign taken_o = eval_i & cond;

  always_comb begin
    if (eval_i && fn_i == JC_ALW)
      AST_ALWAYS_TAKEN: assert (taken_o); // R8
    if (!eval_i || !fn_ok_o)
      AST_IDLE_NOT_TAKEN: assert (!taken_o); // R9
  end
endmodule

// File: rtl/alu_cond_unit.sv
module alu_cond_unit
  import alu_cond_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    src_a_i,
  input  logic [W-1:0]    src_b_i,
  input  logic [FN_W-1:0] op_fn_i,
  input  logic            op_valid_i,
  input  logic [FN_W-1:0] jmp_fn_i,
  input  logic            jmp_eval_i,
  output logic [W-1:0]    result_o,
  output logic            flag_of_o,
  output logic            flag_zf_o,
  output logic            flag_sf_o,
  output logic            taken_o,
  output logic            bad_code_o
);
  flags_t nxt, cur;
  logic   op_ok, jmp_ok, fl_we;

  alu_datapath #(.W(W)) u_dp (
    .a_i(src_a_i), .b_i(src_b_i), .fn_i(op_fn_i),
    .res_o(result_o), .nxt_o(nxt), .fn_ok_o(op_ok)
  );

  assign fl_we = op_valid_i & op_ok;

  flag_reg u_fl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(fl_we), .d_i(nxt), .q_o(cur)
  );

  jump_decoder u_jd (
    .fl_i(cur), .fn_i(jmp_fn_i), .eval_i(jmp_eval_i),
    .taken_o(taken_o), .fn_ok_o(jmp_ok)
  );

  assign bad_code_o = (op_valid_i & ~op_ok) | (jmp_eval_i & ~jmp_ok);
  assign flag_of_o  = cur.of;
  assign flag_zf_o  = cur.zf;
  assign flag_sf_o  = cur.sf;

  AST_BAD_OP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_fn_i > OP_MAX) |=> $stable({flag_of_o, flag_zf_o, flag_sf_o})); // R7
  AST_LOGIC_CLR_OF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && (op_fn_i == OP_AND || op_fn_i == OP_XOR)) |=> !flag_of_o); // R4
  AST_ZERO_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_fn_i <= OP_MAX) |=> flag_zf_o == ($past(result_o) == '0)); // R4
  AST_SIGN_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_fn_i <= OP_MAX) |=> flag_sf_o == $past(result_o[W-1])); // R4
endmodule

// File: tb/sim_alu_cond_unit.sv
module sim_alu_cond_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [3:0]  ofn = '0, jfn = '0;
  logic        ov = 1'b0, je = 1'b0;
  logic [31:0] res;
  logic        f_of, f_zf, f_sf, tk, bad;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  bit m_of = 1'b0, m_zf = 1'b0, m_sf = 1'b0;

  always #10 clk = ~clk;

  alu_cond_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_a_i(a), .src_b_i(b), .op_fn_i(ofn),
    .op_valid_i(ov), .jmp_fn_i(jfn), .jmp_eval_i(je), .result_o(res),
    .flag_of_o(f_of), .flag_zf_o(f_zf), .flag_sf_o(f_sf), .taken_o(tk),
    .bad_code_o(bad)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_res(logic [31:0] x, logic [31:0] y, logic [3:0] f);
    case (f)
      4'd0: return y + x;
      4'd1: return y - x;
      4'd2: return x & y;
      4'd3: return x ^ y;
      default: return 32'h0;
    endcase
  endfunction

  // overflow from a 33-bit signed result that does not fit in 32 bits
  function automatic bit exp_ovf(logic [31:0] x, logic [31:0] y, logic [3:0] f);
    logic signed [32:0] w;
    if (f == 4'd0) w = $signed({y[31], y}) + $signed({x[31], x});
    else if (f == 4'd1) w = $signed({y[31], y}) - $signed({x[31], x});
    else return 1'b0;
    return w[32] != w[31];
  endfunction

  function automatic bit exp_take(logic [3:0] f);
    bit lt;
    lt = (m_sf != m_of);
    case (f)
      4'd0: return 1'b1;
      4'd1: return lt || m_zf;
      4'd2: return lt;
      4'd3: return m_zf;
      4'd4: return !m_zf;
      4'd5: return !lt;
      4'd6: return !lt && !m_zf;
      default: return 1'b0;
    endcase
  endfunction

  task automatic do_op(logic [31:0] x, logic [31:0] y, logic [3:0] f, bit v);
    logic [31:0] r;
    @(negedge clk);
    a = x; b = y; ofn = f; ov = v; je = 1'b0;
    #1;
    r = exp_res(x, y, f);
    if (f <= 4'd1) chk("R1 result", res, r);
    else if (f <= 4'd3) chk("R2 result", res, r);
    else chk("R7 result", res, 32'h0);
    chk("R7 bad_code", {31'h0, bad}, {31'h0, (v && f > 4'd3)});
    if (v && f <= 4'd3) begin
      m_of = exp_ovf(x, y, f); m_zf = (r == 0); m_sf = r[31];
    end
    @(posedge clk); #1;
    if (!v) chk("R5 hold", {29'h0, f_of, f_zf, f_sf}, {29'h0, m_of, m_zf, m_sf});
    else if (f > 4'd3) chk("R7 hold", {29'h0, f_of, f_zf, f_sf}, {29'h0, m_of, m_zf, m_sf});
    else begin
      chk("R3 overflow", {31'h0, f_of}, {31'h0, m_of});
      chk("R4 zero/sign", {30'h0, f_zf, f_sf}, {30'h0, m_zf, m_sf});
    end
    ov = 1'b0;
  endtask

  task automatic do_jmp(logic [3:0] f, bit e);
    @(negedge clk);
    jfn = f; je = e; ov = 1'b0;
    #1;
    if (!e) chk("R9 idle", {31'h0, tk}, 32'h0);
    else if (f > 4'd6) begin
      chk("R9 bad jump taken", {31'h0, tk}, 32'h0);
      chk("R9 bad jump code", {31'h0, bad}, 32'h1);
    end else chk("R8 taken", {31'h0, tk}, {31'h0, exp_take(f)});
    je = 1'b0;
  endtask

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    if (!done) begin
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #5;
    chk("R6 reset flags", {29'h0, f_of, f_zf, f_sf}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    // signed boundaries
    do_op(32'h1, 32'h7FFFFFFF, 4'd0, 1'b1);
    for (int j = 0; j < 8; j++) do_jmp(j[3:0], 1'b1);
    do_op(32'h1, 32'h80000000, 4'd1, 1'b1);
    for (int j = 0; j < 8; j++) do_jmp(j[3:0], 1'b1);
    do_op(32'h1234, 32'h1234, 4'd1, 1'b1);
    for (int j = 0; j < 8; j++) do_jmp(j[3:0], 1'b1);
    do_op(32'hFFFFFFFF, 32'h1, 4'd0, 1'b1);
    do_op(32'hF0F0F0F0, 32'h80000001, 4'd2, 1'b1);
    do_op(32'h7FFFFFFF, 32'h80000000, 4'd1, 1'b1);
    do_op(32'hA5A5A5A5, 32'hA5A5A5A5, 4'd3, 1'b1);
    do_op(32'h0, 32'h0, 4'd5, 1'b1);
    do_op(32'h5, 32'h9, 4'd1, 1'b0);
    do_jmp(4'd0, 1'b0);
    // async reset mid-run
    do_op(32'h80000000, 32'h80000000, 4'd0, 1'b1);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R6 async clear", {29'h0, f_of, f_zf, f_sf}, 32'h0);
    m_of = 0; m_zf = 0; m_sf = 0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      case ($urandom % 4)
        0: x = y;
        1: begin x[31] = 1'b1; y[31] = 1'b0; end
        default: ;
      endcase
      do_op(x, y, 4'($urandom % 6), ($urandom % 5) != 0);
      do_jmp(4'($urandom % 9), ($urandom % 6) != 0);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule